// File: doc/BRIEF.md
# Pipelined Piecewise Cubic Evaluator

This block evaluates a segmented cubic approximation of a function on an already range-reduced fixed-point argument. The upper bits of the argument pick one of 2^IDX_W segments. The lower bits form an unsigned fraction x in [0, 1), which is the polynomial variable. Every segment has its own four coefficients, held in a constant table that is built at elaboration. The value (((c3·x) + c2)·x + c1)·x + c0 is formed by three multiply-add steps.

Between steps the partial result is carried as a sum word plus a carry word, so no step waits for a carry to ripple. A single carry-propagate addition and a round-to-nearest happen only in the last stage. An argument may be presented with `in_valid` on every clock. The matching result appears with `out_valid` four clocks later. Range reduction, reconstruction and floating-point packing belong to the surrounding logic.

Top module: `cubic_seg_eval`

## Requirements
- R1: The argument is split with its top IDX_W bits (bits 15:10 by default) as the segment number and its low XW bits (9:0) as x, read as an unsigned fraction equal to the field value divided by 2^XW.
- R2: The coefficient table is defined as follows. For segment n and coefficient k, raw = n·M_k + A_k. The low 18 bits of raw are taken as a two's-complement integer and scaled by 2^-16. The constants are: k=0 (M 40503, A 12345), k=1 (M 9973, A 200001), k=2 (M 77773, A 5555), k=3 (M 104729, A 171717).
- R3: For every argument, `out_y` read as a signed 20-bit value with 16 fractional bits is within one unit of 2^-16 of the exact value of c3·x³ + c2·x² + c1·x + c0.
- R4: When x is zero, `out_y` equals the segment's c0 exactly.
- R5: `out_valid` rises exactly four clock edges after the edge that accepts an argument, and carries the result for that argument.
- R6: Arguments presented on consecutive cycles are all accepted, and their results leave on consecutive cycles in the same order.
- R7: A cycle with `in_valid` low yields a cycle with `out_valid` low four edges later, and the other results keep their positions.
- R8: A synchronous reset clears every valid flag in the pipeline. `out_valid` is low after any edge with `rst` high, and arguments already in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Argument on `in_arg` is accepted at this edge |
| in_arg | input | IDX_W+XW (16) | Segment number in the upper bits, fraction x in the lower bits |
| out_valid | output | 1 | `out_y` holds a result |
| out_y | output | OW (20) | Signed result with OF (16) fractional bits |

## Verification
The clocked properties assume that `in_valid` is a known level on every edge after reset. They also assume that a reset arriving in the middle of an argument's four-edge journey should simply cancel the check, which is why each one is disabled while `rst` is high. The stimulus drives `in_valid`, `in_arg` and `rst` only between rising edges and only to defined values. It raises `rst` while arguments are still in flight, so that the discard rule is exercised and not just assumed. The data path takes any 16-bit argument, and every argument value is sent, so no input constraint limits the accuracy check.

// File: rtl/cse_pkg.sv
package cse_pkg;

    // Generator for the per-segment coefficient set: raw = seg*mul + add,
    // low w bits taken as a two's-complement integer.
    function automatic int seg_coef(input int k, input int seg, input int w);
        longint mul;
        longint add;
        longint t;
        longint span;
        case (k)
            0:       begin mul = 40503;  add = 12345;  end
            1:       begin mul = 9973;   add = 200001; end
            2:       begin mul = 77773;  add = 5555;   end
            default: begin mul = 104729; add = 171717; end
        endcase
        span = longint'(1) << w;
        t = (longint'(seg) * mul + add) % span;
        if (t >= span / 2) t = t - span;
        return int'(t);
    endfunction

endpackage

// File: rtl/cse_coef_rom.sv
module cse_coef_rom #(
    parameter int IDX_W = 6,
    parameter int CW    = 18,
    parameter int KSEL  = 0
) (
    input  logic [IDX_W-1:0]     idx_i,
    output logic signed [CW-1:0] coef_o
);
    localparam int NSEG = 1 << IDX_W;

    logic signed [CW-1:0] tbl [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_entry
        assign tbl[i] = CW'(cse_pkg::seg_coef(KSEL, i, CW));
    end

    assign coef_o = tbl[idx_i];

endmodule

// File: rtl/cse_csa_mac.sv
module cse_csa_mac #(
    parameter int XW    = 10,
    parameter int AW    = 28,
    parameter int CW    = 18,
    parameter int SHIFT = 4
) (
    input  logic signed [AW-1:0] s_i,
    input  logic signed [AW-1:0] c_i,
    input  logic [XW-1:0]        x_i,
    input  logic signed [CW-1:0] k_i,
    output logic signed [AW-1:0] s_o,
    output logic signed [AW-1:0] c_o
);
    localparam int PW = AW + XW + 1;

    logic signed [XW:0]   xs;
    logic signed [PW-1:0] ps_full;
    logic signed [PW-1:0] pc_full;
    logic signed [AW-1:0] ps;
    logic signed [AW-1:0] pc;
    logic signed [AW-1:0] kx;

    always_comb begin
        xs      = signed'({1'b0, x_i});
        // each redundant half is scaled by x on its own
        ps_full = PW'(s_i) * PW'(xs);
        pc_full = PW'(c_i) * PW'(xs);
        ps      = AW'(ps_full >>> XW);
        pc      = AW'(pc_full >>> XW);
        kx      = AW'(k_i) <<< SHIFT;
        // 3:2 compression folds in the coefficient without a carry chain
        s_o     = ps ^ pc ^ kx;
        c_o     = ((ps & pc) | (ps & kx) | (pc & kx)) << 1;
    end

endmodule

// File: rtl/cse_horner_step.sv
module cse_horner_step #(
    parameter int IDX_W = 6,
    parameter int XW    = 10,
    parameter int CW    = 18,
    parameter int CF    = 16,
    parameter int AF    = 20,
    parameter int AW    = 28,
    parameter int KSEL  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        v_i,
    input  logic [IDX_W+XW-1:0]         arg_i,
    input  logic signed [AW-1:0]        s_i,
    input  logic signed [AW-1:0]        c_i,
    output logic                        v_o,
    output logic [IDX_W+XW-1:0]         arg_o,
    output logic signed [AW-1:0]        s_o,
    output logic signed [AW-1:0]        c_o
);
    localparam int ARG_W = IDX_W + XW;

    typedef struct packed {
        logic                 v;
        logic [ARG_W-1:0]     arg;
        logic signed [AW-1:0] s;
        logic signed [AW-1:0] c;
    } hstep_t;

    hstep_t               st_d;
    hstep_t               st_q;
    logic signed [CW-1:0] coef;
    logic signed [AW-1:0] s_new;
    logic signed [AW-1:0] c_new;

    cse_coef_rom #(.IDX_W(IDX_W), .CW(CW), .KSEL(KSEL)) u_rom (
        .idx_i  (arg_i[ARG_W-1:XW]),
        .coef_o (coef)
    );

    cse_csa_mac #(.XW(XW), .AW(AW), .CW(CW), .SHIFT(AF-CF)) u_mac (
        .s_i (s_i),
        .c_i (c_i),
        .x_i (arg_i[XW-1:0]),
        .k_i (coef),
        .s_o (s_new),
        .c_o (c_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.v   = v_i;
        st_d.arg = arg_i;
        st_d.s   = s_new;
        st_d.c   = c_new;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) st_q.v <= 1'b0;
    end

    assign v_o   = st_q.v;
    assign arg_o = st_q.arg;
    assign s_o   = st_q.s;
    assign c_o   = st_q.c;

    // R6: a valid entry always moves on one stage per edge
    p_step_advance_r6: assert property (@(posedge clk) disable iff (rst)
        v_i |=> v_o);

    // R7: an empty slot stays empty as it moves
    p_step_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        !v_i |=> !v_o);

    // R1: the argument travels unchanged alongside its partial result
    p_step_arg_r1: assert property (@(posedge clk) disable iff (rst)
        v_i |=> (arg_o == $past(arg_i)));

endmodule

// File: rtl/cse_final_step.sv
module cse_final_step #(
    parameter int IDX_W = 6,
    parameter int XW    = 10,
    parameter int CW    = 18,
    parameter int CF    = 16,
    parameter int AF    = 20,
    parameter int AW    = 28,
    parameter int OW    = 20,
    parameter int OF    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_i,
    input  logic [IDX_W+XW-1:0]  arg_i,
    input  logic signed [AW-1:0] s_i,
    input  logic signed [AW-1:0] c_i,
    output logic                 v_o,
    output logic signed [OW-1:0] y_o
);
    localparam int ARG_W = IDX_W + XW;
    localparam int DROP  = AF - OF;
    localparam int HALF  = 1 << (DROP - 1);

    typedef struct packed {
        logic                 v;
        logic signed [OW-1:0] y;
    } fstep_t;

    fstep_t               st_d;
    fstep_t               st_q;
    logic signed [CW-1:0] coef;
    logic signed [AW-1:0] s_new;
    logic signed [AW-1:0] c_new;
    logic signed [AW-1:0] total;
    logic signed [AW-1:0] rounded;

    cse_coef_rom #(.IDX_W(IDX_W), .CW(CW), .KSEL(0)) u_rom (
        .idx_i  (arg_i[ARG_W-1:XW]),
        .coef_o (coef)
    );

    cse_csa_mac #(.XW(XW), .AW(AW), .CW(CW), .SHIFT(AF-CF)) u_mac (
        .s_i (s_i),
        .c_i (c_i),
        .x_i (arg_i[XW-1:0]),
        .k_i (coef),
        .s_o (s_new),
        .c_o (c_new)
    );

    always_comb begin
        st_d    = st_q;
        // the only carry-propagate addition in the datapath
        total   = s_new + c_new;
        rounded = (total + AW'(HALF)) >>> DROP;
        st_d.v  = v_i;
        st_d.y  = OW'(rounded);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) st_q.v <= 1'b0;
    end

    assign v_o = st_q.v;
    assign y_o = st_q.y;

    // R5: the last stage never adds or drops a result
    p_final_valid_r5: assert property (@(posedge clk) disable iff (rst)
        v_i |=> v_o);

    p_final_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        !v_i |=> !v_o);

endmodule

// File: rtl/cubic_seg_eval.sv
module cubic_seg_eval #(
    parameter int IDX_W = 6,
    parameter int XW    = 10,
    parameter int CW    = 18,
    parameter int CF    = 16,
    parameter int AF    = 20,
    parameter int OW    = 20,
    parameter int OF    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [IDX_W+XW-1:0]    in_arg,
    output logic                   out_valid,
    output logic signed [OW-1:0]   out_y
);
    localparam int ARG_W  = IDX_W + XW;
    // guard for the worst-case growth of the redundant pair over three steps
    localparam int AW     = AF + (CW - CF) + 6;
    localparam int NSTEP  = 2;

    typedef struct packed {
        logic                 v;
        logic [ARG_W-1:0]     arg;
        logic signed [AW-1:0] acc;
    } lead_t;

    lead_t                lead_d;
    lead_t                lead_q;
    logic signed [CW-1:0] c3;

    logic                 v_w   [NSTEP+1];
    logic [ARG_W-1:0]     a_w   [NSTEP+1];
    logic signed [AW-1:0] s_w   [NSTEP+1];
    logic signed [AW-1:0] c_w   [NSTEP+1];

    // stage 1: segment lookup of the leading coefficient
    cse_coef_rom #(.IDX_W(IDX_W), .CW(CW), .KSEL(3)) u_rom_c3 (
        .idx_i  (in_arg[ARG_W-1:XW]),
        .coef_o (c3)
    );

    always_comb begin
        lead_d     = lead_q;
        lead_d.v   = in_valid;
        lead_d.arg = in_arg;
        lead_d.acc = AW'(c3) <<< (AF - CF);
    end

    always_ff @(posedge clk) begin
        lead_q <= lead_d;
        if (rst) lead_q.v <= 1'b0;
    end

    assign v_w[0] = lead_q.v;
    assign a_w[0] = lead_q.arg;
    assign s_w[0] = lead_q.acc;
    assign c_w[0] = '0;

    // stages 2 and 3: redundant multiply-add with c2, then c1
    for (genvar j = 0; j < NSTEP; j++) begin : g_step
        cse_horner_step #(
            .IDX_W(IDX_W), .XW(XW), .CW(CW), .CF(CF), .AF(AF), .AW(AW),
            .KSEL(NSTEP - j)
        ) u_step (
            .clk   (clk),
            .rst   (rst),
            .v_i   (v_w[j]),
            .arg_i (a_w[j]),
            .s_i   (s_w[j]),
            .c_i   (c_w[j]),
            .v_o   (v_w[j+1]),
            .arg_o (a_w[j+1]),
            .s_o   (s_w[j+1]),
            .c_o   (c_w[j+1])
        );
    end

    // stage 4: multiply-add with c0, resolve and round
    cse_final_step #(
        .IDX_W(IDX_W), .XW(XW), .CW(CW), .CF(CF), .AF(AF), .AW(AW),
        .OW(OW), .OF(OF)
    ) u_final (
        .clk   (clk),
        .rst   (rst),
        .v_i   (v_w[NSTEP]),
        .arg_i (a_w[NSTEP]),
        .s_i   (s_w[NSTEP]),
        .c_i   (c_w[NSTEP]),
        .v_o   (out_valid),
        .y_o   (out_y)
    );

    // R5: fixed four-edge latency from accepted argument to result
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##4 out_valid);

    // R7: idle input cycles reappear as idle output cycles
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##4 !out_valid);

    // R8: reset empties the pipeline at once
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/tb_cubic_seg_eval.sv
`timescale 1ns/1ps
module tb_cubic_seg_eval;
    localparam int IDX_W = 6;
    localparam int XW    = 10;
    localparam int OW    = 20;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [15:0]          in_arg = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_y;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    logic  mv [4];
    logic [15:0] ma [4];
    string mt [4];

    always #2.5 clk = ~clk;

    cubic_seg_eval #(.IDX_W(IDX_W), .XW(XW), .OW(OW)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_arg    (in_arg),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    // R2 coefficient definition
    function automatic longint coef(input int k, input int seg);
        longint m;
        longint a;
        longint t;
        case (k)
            0:       begin m = 40503;  a = 12345;  end
            1:       begin m = 9973;   a = 200001; end
            2:       begin m = 77773;  a = 5555;   end
            default: begin m = 104729; a = 171717; end
        endcase
        t = (longint'(seg) * m + a) & 64'h3FFFF;
        if (t >= 131072) t = t - 262144;
        return t;
    endfunction

    task automatic check_out(input string vtag);
        int     seg;
        longint x;
        longint exact;
        longint yo;
        longint diff;
        string  tag;
        checks++;
        if (out_valid !== mv[3]) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", vtag, out_valid, mv[3]);
        end else if (mv[3]) begin
            seg   = int'(ma[3][15:10]);
            x     = longint'(ma[3][9:0]);
            exact = ((coef(3, seg) * x + coef(2, seg) * 1024) * x
                     + coef(1, seg) * 1048576) * x + coef(0, seg) * 1073741824;
            yo    = longint'(out_y);
            checks++;
            if (x == 0) begin
                tag = (mt[3] != "") ? mt[3] : "R4";
                if (yo != coef(0, seg)) begin
                    errors++;
                    $display("FAIL %s arg %h actual %0d expected %0d", tag, ma[3], yo, coef(0, seg));
                end
            end else begin
                tag  = (mt[3] != "") ? mt[3] : "R3";
                diff = yo * 1073741824 - exact;
                if (diff < 0) diff = -diff;
                if (diff > 1073741824) begin
                    errors++;
                    $display("FAIL %s arg %h actual %0d expected %f", tag, ma[3], yo,
                             $itor(exact) / 1073741824.0);
                end
            end
        end
    endtask

    task automatic cycle(input logic v, input logic [15:0] a, input logic r,
                         input string vtag, input string dtag);
        in_valid = v;
        in_arg   = a;
        rst      = r;
        @(posedge clk);
        for (int j = 3; j > 0; j--) begin
            mv[j] = mv[j-1];
            ma[j] = ma[j-1];
            mt[j] = mt[j-1];
        end
        mv[0] = v;
        ma[0] = a;
        mt[0] = dtag;
        if (r) for (int j = 0; j < 4; j++) mv[j] = 1'b0;
        @(negedge clk);
        check_out(vtag);
    endtask

    initial begin
        int lf;
        for (int j = 0; j < 4; j++) begin
            mv[j] = 1'b0;
            ma[j] = '0;
            mt[j] = "";
        end
        // R8: reset state, with arguments offered during reset ignored
        for (int i = 0; i < 3; i++) cycle(1'b1, 16'h1234, 1'b1, "R8", "");
        for (int i = 0; i < 5; i++) cycle(1'b0, 16'h0, 1'b0, "R8", "");
        // R5: a lone argument appears after exactly four edges
        cycle(1'b1, {6'd9, 10'd517}, 1'b0, "R5", "R5");
        for (int i = 0; i < 6; i++) cycle(1'b0, 16'h0, 1'b0, "R5", "");
        // R1: upper bits pick the segment, lower bits are x
        cycle(1'b1, {6'd5, 10'd0}, 1'b0, "R1", "R1");
        cycle(1'b1, {6'd63, 10'd1023}, 1'b0, "R1", "R1");
        cycle(1'b1, {6'd0, 10'd1}, 1'b0, "R1", "R1");
        // R2: every segment's table entry seen at x = 0
        for (int s = 0; s < 64; s++) cycle(1'b1, {s[5:0], 10'd0}, 1'b0, "R2", "R2");
        for (int i = 0; i < 4; i++) cycle(1'b0, 16'h0, 1'b0, "R2", "");
        // R8: reset with a full pipeline drops in-flight results
        for (int i = 0; i < 4; i++) cycle(1'b1, 16'hA5A5 + 16'(i), 1'b0, "R8", "");
        cycle(1'b1, 16'h7777, 1'b1, "R8", "");
        for (int i = 0; i < 6; i++) cycle(1'b0, 16'h0, 1'b0, "R8", "");
        // R3, R4, R6: every argument, back to back
        for (int a = 0; a < 65536; a++) cycle(1'b1, 16'(a), 1'b0, "R6", "");
        // R7: irregular gaps between arguments
        lf = 32'h1ACE;
        for (int i = 0; i < 3000; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >>> 17);
            lf = lf ^ (lf << 5);
            cycle(lf[3] | lf[9], lf[27:12], 1'b0, "R7", "");
        end
        for (int i = 0; i < 6; i++) cycle(1'b0, 16'h0, 1'b0, "R7", "");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule